// File: doc/BRIEF.md
# Raster-Paced Audio and Motor-Speed Word Fetcher

This block reads one 16-bit word per video scan line from a small RAM buffer and turns it into two 8-bit converter codes. The upper byte of each word feeds the audio converter and the lower byte feeds the converter that sets the floppy motor speed, so the two streams are interleaved word by word in a single buffer. The raster timing supplies a strobe per scan line, including the blanking lines, and a frame-start flag. With 370 lines per frame, the sample rate equals the line rate, about 22.256 kHz.

For every line strobe the block sends one read request with a byte address to the RAM arbiter. When the read data comes back it updates both codes together and pulses a sample strobe. Two port bits control it. One selects between a primary buffer at 0x1FD00 and a secondary buffer at 0x1A100, and the block latches that choice only when a frame begins. The other enables audio; when audio is off, the audio code is forced to midscale while the motor-speed code keeps tracking the buffer.

Top module: `line_sample_fetcher`

## Requirements
- R1: After reset, rd_req and sample_stb are 0, snd_dac is 0x80 and spd_dac is 0x00.
- R2: Each cycle with line_stb high produces rd_req high for exactly the following cycle. rd_req is low in every other cycle.
- R3: The request address is base + 2*index, where index is the word position 0..369. Index rises by one per line strobe and returns to 0 after 369, without any frame start.
- R4: A line strobe with frame_start high fetches index 0, whatever the index was, and the next line fetches index 1.
- R5: The base is 0x1FD00 when the latched select is 0 and 0x1A100 when it is 1. buf_alt is sampled only on a line strobe that carries frame_start. A change of buf_alt at any other time does not alter the address until the next frame start.
- R6: One cycle after rd_valid, sample_stb is high for one cycle, spd_dac holds rd_data[7:0] and, with audio enabled, snd_dac holds rd_data[15:8].
- R7: If snd_en is low in the rd_valid cycle, snd_dac becomes 0x80 at the strobe while spd_dac still takes rd_data[7:0].
- R8: snd_dac and spd_dac change only in cycles where sample_stb is high.
- R9: frame_start without line_stb has no effect. The next line continues the index sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per scan line |
| frame_start | input | 1 | Marks the line strobe that opens a frame |
| buf_alt | input | 1 | Buffer choice: 0 primary, 1 secondary |
| snd_en | input | 1 | Audio enable; low forces audio code to midscale |
| rd_req | output | 1 | Read request to RAM, one cycle |
| rd_addr | output | 17 | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Returned word: audio high byte, motor-speed low byte |
| snd_dac | output | 8 | Audio converter code |
| spd_dac | output | 8 | Motor-speed converter code |
| sample_stb | output | 1 | Pulses when both codes are updated |

## Verification
Frame restart and index wrap can act on the same line strobe: a frame start may come on the strobe that would otherwise fetch word 369, or early in the middle of a frame. The bench sends line strobes with frame_start set at index 369 and at index 5, and it also lets a strobe without a frame start fall through 369 to 0. In each case it compares the issued address with an index and base model kept in the bench. A change of buf_alt in the middle of a frame is placed against a later frame start, and the address must keep the old base until that restart and then take the new one.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
   localparam int unsigned LSF_WORDS     = 370;
   localparam int unsigned LSF_ADDR_W    = 17;
   localparam int unsigned LSF_DAC_W     = 8;
   localparam int unsigned LSF_MAIN_BASE = 32'h1FD00;
   localparam int unsigned LSF_ALT_BASE  = 32'h1A100;

   typedef enum logic {
      BUF_PRIMARY   = 1'b0,
      BUF_SECONDARY = 1'b1
   } buf_pick_e;
endpackage

// File: rtl/lsf_word_idx.sv
module lsf_word_idx #(
   parameter int unsigned WORDS = 370,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             restart,
   output logic [IDX_W-1:0] fetch_idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   logic [IDX_W-1:0] idx_q;

   generate
      if (WORDS < 2) begin : g_bad_words
         $error("lsf_word_idx: WORDS must be at least 2");
      end
   endgenerate

   assign fetch_idx = restart ? '0 : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= (fetch_idx == LAST) ? '0 : fetch_idx + 1'b1;
      end
   end

   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);

   // R3
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && idx_q == LAST) |=> idx_q == '0);

   // R4
   idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && restart) |=> idx_q == IDX_W'(1));
endmodule

// File: rtl/lsf_addr_gen.sv
module lsf_addr_gen
   import lsf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned WORDS     = 370,
   parameter int unsigned MAIN_BASE = 32'h1FD00,
   parameter int unsigned ALT_BASE  = 32'h1A100,
   parameter bit          BYTE_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch,
   input  logic              restart,
   input  logic              sel_in,
   input  logic [IDX_W-1:0]  idx,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam longint unsigned SPAN = 2 * longint'(WORDS);
   localparam logic [ADDR_W-1:0] BASE_P = ADDR_W'(MAIN_BASE);
   localparam logic [ADDR_W-1:0] BASE_S = ADDR_W'(ALT_BASE);

   buf_pick_e         sel_q;
   buf_pick_e         sel_now;
   logic [ADDR_W-1:0] base_now;
   logic [ADDR_W-1:0] offset;

   generate
      if ((longint'(MAIN_BASE) + SPAN) > (64'd1 << ADDR_W) ||
          (longint'(ALT_BASE)  + SPAN) > (64'd1 << ADDR_W)) begin : g_bad_span
         $error("lsf_addr_gen: a buffer does not fit in ADDR_W bits");
      end
      if (BYTE_ADDR) begin : g_byte
         assign offset = ADDR_W'({idx, 1'b0});
      end else begin : g_word
         assign offset = ADDR_W'(idx);
      end
   endgenerate

   assign sel_now = restart ? buf_pick_e'(sel_in) : sel_q;

   always_comb begin
      if (BYTE_ADDR) begin
         base_now = (sel_now == BUF_SECONDARY) ? BASE_S : BASE_P;
      end else begin
         base_now = (sel_now == BUF_SECONDARY) ? (BASE_S >> 1) : (BASE_P >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= BUF_PRIMARY;
         rd_req  <= 1'b0;
         rd_addr <= '0;
      end else begin
         rd_req <= fetch;
         if (fetch) begin
            rd_addr <= base_now + offset;
            if (restart) sel_q <= buf_pick_e'(sel_in);
         end
      end
   end

   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> $past(fetch));

   // R5
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch && restart) |=> $stable(sel_q));
endmodule

// File: rtl/lsf_dac_split.sv
module lsf_dac_split #(
   parameter int unsigned DAC_W = 8,
   localparam int unsigned DATA_W = 2 * DAC_W,
   localparam logic [DAC_W-1:0] MIDSCALE = DAC_W'(1) << (DAC_W - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              snd_en,
   output logic [DAC_W-1:0]  snd_dac,
   output logic [DAC_W-1:0]  spd_dac,
   output logic              sample_stb
);
   logic [DAC_W-1:0] hi_byte;
   logic [DAC_W-1:0] lo_byte;

   assign hi_byte = rd_data[DATA_W-1:DAC_W];
   assign lo_byte = rd_data[DAC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snd_dac    <= MIDSCALE;
         spd_dac    <= '0;
         sample_stb <= 1'b0;
      end else begin
         sample_stb <= rd_valid;
         if (rd_valid) begin
            snd_dac <= snd_en ? hi_byte : MIDSCALE;
            spd_dac <= lo_byte;
         end
      end
   end

   // R6
   split_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> (sample_stb && spd_dac == $past(lo_byte)));

   // R7
   mute_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !snd_en) |=> snd_dac == MIDSCALE);

   // R8
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |-> ($stable(snd_dac) && $stable(spd_dac)));
endmodule

// File: rtl/line_sample_fetcher.sv
module line_sample_fetcher
   import lsf_pkg::*;
#(
   parameter int unsigned WORDS     = LSF_WORDS,
   parameter int unsigned ADDR_W    = LSF_ADDR_W,
   parameter int unsigned DAC_W     = LSF_DAC_W,
   parameter int unsigned MAIN_BASE = LSF_MAIN_BASE,
   parameter int unsigned ALT_BASE  = LSF_ALT_BASE,
   parameter bit          BYTE_ADDR = 1'b1,
   localparam int unsigned IDX_W  = $clog2(WORDS),
   localparam int unsigned DATA_W = 2 * DAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              frame_start,
   input  logic              buf_alt,
   input  logic              snd_en,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DAC_W-1:0]  snd_dac,
   output logic [DAC_W-1:0]  spd_dac,
   output logic              sample_stb
);
   logic             restart;
   logic [IDX_W-1:0] fetch_idx;

   assign restart = line_stb & frame_start;

   lsf_word_idx #(.WORDS(WORDS)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (line_stb),
      .restart   (restart),
      .fetch_idx (fetch_idx)
   );

   lsf_addr_gen #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .WORDS     (WORDS),
      .MAIN_BASE (MAIN_BASE),
      .ALT_BASE  (ALT_BASE),
      .BYTE_ADDR (BYTE_ADDR)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .fetch   (line_stb),
      .restart (restart),
      .sel_in  (buf_alt),
      .idx     (fetch_idx),
      .rd_req  (rd_req),
      .rd_addr (rd_addr)
   );

   lsf_dac_split #(.DAC_W(DAC_W)) u_dac (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .snd_en     (snd_en),
      .snd_dac    (snd_dac),
      .spd_dac    (spd_dac),
      .sample_stb (sample_stb)
   );

   // R2
   line_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> rd_req);

   // R9
   lone_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !line_stb) |=> !rd_req);
endmodule

// File: tb/line_sample_fetcher_test.sv
module line_sample_fetcher_test;
   localparam int MAIN = 32'h1FD00;
   localparam int ALT  = 32'h1A100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_stb = 1'b0;
   logic        frame_start = 1'b0;
   logic        buf_alt = 1'b0;
   logic        snd_en = 1'b1;
   logic        rd_req;
   logic [16:0] rd_addr;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [7:0]  snd_dac;
   logic [7:0]  spd_dac;
   logic        sample_stb;

   int checks = 0;
   int fails = 0;
   int nxt_idx = 0;
   bit cur_alt = 1'b0;

   always #5 clk = ~clk;

   line_sample_fetcher uut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_start(frame_start),
      .buf_alt(buf_alt), .snd_en(snd_en), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .snd_dac(snd_dac),
      .spd_dac(spd_dac), .sample_stb(sample_stb)
   );

   function automatic logic [15:0] mem_word(input logic [16:0] a);
      return a[16:1] ^ 16'h6C39;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         rd_data  <= mem_word(rd_addr);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One scan line: strobe, request check, data return, code update check.
   task automatic do_line(input bit fs, input bit en, input string tag);
      int idx;
      int addr;
      logic [15:0] w;
      logic [7:0] s0, p0;
      if (fs) cur_alt = buf_alt;
      idx = fs ? 0 : nxt_idx;
      addr = (cur_alt ? ALT : MAIN) + 2 * idx;
      nxt_idx = (idx == 369) ? 0 : idx + 1;
      w = mem_word(17'(addr));
      s0 = snd_dac;
      p0 = spd_dac;
      @(negedge clk);
      line_stb = 1'b1; frame_start = fs; snd_en = en;
      @(negedge clk);
      line_stb = 1'b0; frame_start = 1'b0;
      chk(rd_req == 1'b1, "R2 request", int'(rd_req), 1);
      chk(rd_addr == 17'(addr), tag, int'(rd_addr), addr);
      chk(sample_stb == 1'b0 && snd_dac == s0 && spd_dac == p0, "R8 hold",
          int'({snd_dac, spd_dac}), int'({s0, p0}));
      @(negedge clk);
      chk(rd_req == 1'b0, "R2 single", int'(rd_req), 0);
      @(negedge clk);
      chk(sample_stb == 1'b1, "R6 strobe", int'(sample_stb), 1);
      chk(spd_dac == w[7:0], "R6 speed byte", int'(spd_dac), int'(w[7:0]));
      if (en) chk(snd_dac == w[15:8], "R6 sound byte", int'(snd_dac), int'(w[15:8]));
      else    chk(snd_dac == 8'h80, "R7 muted", int'(snd_dac), 'h80);
      @(negedge clk);
      chk(sample_stb == 1'b0, "R6 one pulse", int'(sample_stb), 0);
   endtask

   task automatic t_reset();
      chk(rd_req == 1'b0, "R1 req", int'(rd_req), 0);
      chk(sample_stb == 1'b0, "R1 stb", int'(sample_stb), 0);
      chk(snd_dac == 8'h80, "R1 snd", int'(snd_dac), 'h80);
      chk(spd_dac == 8'h00, "R1 spd", int'(spd_dac), 0);
   endtask

   task automatic t_full_frame();
      buf_alt = 1'b0;
      do_line(1'b1, 1'b1, "R4 first word");
      for (int i = 1; i < 370; i++) do_line(1'b0, 1'b1, "R3 frame walk");
      do_line(1'b0, 1'b1, "R3 wrap to 0");
      do_line(1'b0, 1'b1, "R3 after wrap");
   endtask

   task automatic t_select_midframe();
      @(negedge clk) buf_alt = 1'b1;
      for (int i = 0; i < 3; i++) do_line(1'b0, 1'b1, "R5 select ignored");
      do_line(1'b1, 1'b1, "R5 secondary base");
      for (int i = 0; i < 4; i++) do_line(1'b0, 1'b1, "R5 secondary walk");
      @(negedge clk) buf_alt = 1'b0;
      do_line(1'b1, 1'b1, "R5 primary again");
   endtask

   task automatic t_early_restart();
      for (int i = 0; i < 4; i++) do_line(1'b0, 1'b1, "R3 walk");
      do_line(1'b1, 1'b1, "R4 early restart");
      do_line(1'b0, 1'b1, "R4 index one");
   endtask

   task automatic t_restart_at_last();
      while (nxt_idx != 369) do_line(1'b0, 1'b1, "R3 run to end");
      do_line(1'b1, 1'b1, "R4 restart on 369");
      do_line(1'b0, 1'b1, "R4 then index one");
   endtask

   task automatic t_lone_frame();
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      chk(rd_req == 1'b0, "R9 no request", int'(rd_req), 0);
      do_line(1'b0, 1'b1, "R9 index continues");
   endtask

   task automatic t_mute();
      for (int i = 0; i < 3; i++) do_line(1'b0, 1'b0, "R7 muted walk");
      do_line(1'b0, 1'b1, "R7 unmuted");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_frame();
      t_select_midframe();
      t_early_restart();
      t_lone_frame();
      t_mute();
      t_restart_at_last();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1500000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule